// File: doc/BRIEF.md
# UTOPIA Level 2 Receive PHY Port

This block is the PHY-side slave on the receive half of a UTOPIA Level 2 bus, carrying cells from the PHY to the ATM layer. An upstream source writes cell bytes into a small buffer of whole-cell slots. A slot counts as ready only once all 53 of its bytes have arrived. The ATM-layer master polls the shared bus by presenting port addresses. When this port's programmed 5-bit address is seen, the block drives its cell-available flag on the next cycle. At every other time that flag is released to high impedance.

To read a cell, the master presents this port's address while its active-low enable is high, which selects the port. It then pulls the enable low. On each clock edge where the enable is low and a cell is held, one byte is handed out on the following cycle. That byte comes with an odd-parity bit, and a start-of-cell flag marks the first byte. The master may raise the enable at any byte to pause, and the transfer resumes where it stopped. Data, parity and start-of-cell are driven only in cycles that carry a byte. After a cell's last byte its slot is freed and the cell-available flag describes the next stored cell.

Top module: `utopia_rx_port`

## Requirements
- R1: After reset, `rx_clav_oe` and `rx_dat_oe` are 0 and `wr_ready` is 1.
- R2: `rx_clav_oe` is 1 in the cycle after a clock edge at which `rx_addr` equalled `port_addr`, and 0 after any other edge.
- R3: When driven, `rx_clav` is 1 exactly when the buffer holds at least one complete cell whose transfer has not begun at that edge.
- R4: At an edge with `rx_en_n` = 1, the port becomes selected if `rx_addr` equals `port_addr` and deselected otherwise. While `rx_en_n` = 0, the selection does not change.
- R5: After an edge where the port was selected, `rx_en_n` was 0 and a complete cell was held, `rx_dat_oe` is 1 and `rx_data` carries the next byte in the order it was written. After any other edge, `rx_dat_oe` is 0 and no byte is consumed.
- R6: `rx_soc` is 1 with the first byte of every cell and 0 otherwise.
- R7: `rx_parity` makes the nine bits {`rx_parity`, `rx_data`} contain an odd number of ones, so a zero byte carries parity 1.
- R8: A cell is 53 bytes. After its last byte the slot is released, and the next byte sent is byte 0 of the next stored cell.
- R9: `wr_ready` is 1 while fewer than SLOTS (default 2) complete cells are stored. A write with `wr_en` = 1 while `wr_ready` = 0 is discarded and never appears on `rx_data`.
- R10: When a cell's last byte is written at the same edge as another cell's last byte is read, both take effect: the stored-cell count is unchanged and both byte streams stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 5 | Programmed bus address of this port |
| wr_en | input | 1 | Upstream byte write strobe |
| wr_data | input | 8 | Upstream byte |
| wr_ready | output | 1 | A free slot exists, so writes are accepted |
| rx_addr | input | 5 | Address presented by the ATM-layer master |
| rx_en_n | input | 1 | Active-low transfer enable from the master |
| rx_data | output | 8 | Cell byte to the master |
| rx_parity | output | 1 | Odd parity of `rx_data` |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_dat_oe | output | 1 | Output enable for data, parity and start-of-cell |
| rx_clav | output | 1 | Cell-available answer to a poll |
| rx_clav_oe | output | 1 | Output enable for `rx_clav` |

## Verification
The upstream side can complete a cell in the same edge at which the bus side sends the final byte of another cell. At that edge the stored-cell count gets an increment and a decrement together. The bench forces this case on purpose: it fills one full cell plus 52 bytes of a second, reads the first cell up to its last byte, and then applies the last write and the last read together. The case is judged by a reference model that requires a following poll to report a ready cell and requires the second cell to read back byte for byte. Random phases then overlap writes, polls, pauses and reads, both while the buffer is full and while it is empty.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int unsigned DEF_CELL_BYTES = 53;
    localparam int unsigned DEF_SLOTS      = 2;
    localparam int unsigned DEF_DATA_W     = 8;
    localparam int unsigned DEF_ADDR_W     = 5;
endpackage

// File: rtl/rxp_cell_store.sv
module rxp_cell_store #(
    parameter int unsigned DEPTH  = 106,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxp_fill.sv
module rxp_fill #(
    parameter int unsigned CELL_BYTES = 53,
    parameter int unsigned SLOTS      = 2,
    localparam int unsigned IDX_W     = $clog2(CELL_BYTES),
    localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              commit
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
    } fill_t;

    fill_t f_d, f_q;
    logic  at_end;

    always_comb begin
        f_d    = f_q;
        at_end = (f_q.idx == IDX_W'(CELL_BYTES - 1));
        commit = accept && at_end;
        if (accept) begin
            if (at_end) begin
                f_d.idx  = '0;
                f_d.slot = (f_q.slot == SLOT_W'(SLOTS - 1)) ? '0 : f_q.slot + 1'b1;
            end else begin
                f_d.idx = f_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign wr_slot = f_q.slot;
    assign wr_idx  = f_q.idx;

    // R8
    cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.idx < IDX_W'(CELL_BYTES));
endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port #(
    parameter int unsigned CELL_BYTES = rxp_pkg::DEF_CELL_BYTES,
    parameter int unsigned SLOTS      = rxp_pkg::DEF_SLOTS,
    parameter int unsigned DATA_W     = rxp_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W     = rxp_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_en_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_parity,
    output logic              rx_soc,
    output logic              rx_dat_oe,
    output logic              rx_clav,
    output logic              rx_clav_oe
);
    localparam int unsigned IDX_W     = $clog2(CELL_BYTES);
    localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned CNT_W     = $clog2(SLOTS + 1);
    localparam int unsigned MEM_DEPTH = SLOTS * CELL_BYTES;
    localparam int unsigned MEM_W     = $clog2(MEM_DEPTH);

    typedef struct packed {
        logic              sel;
        logic              clav_oe;
        logic              clav;
        logic              dat_oe;
        logic [DATA_W-1:0] data;
        logic              par;
        logic              soc;
        logic [SLOT_W-1:0] rd_slot;
        logic [IDX_W-1:0]  rd_idx;
        logic [CNT_W-1:0]  full_cnt;
    } port_t;

    port_t s_d, s_q;

    logic              wr_accept;
    logic [SLOT_W-1:0] wr_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic              commit;
    logic [MEM_W-1:0]  waddr, raddr;
    logic [DATA_W-1:0] rdata;
    logic              avail, take, last;

    assign wr_ready  = (s_q.full_cnt < CNT_W'(SLOTS));
    assign wr_accept = wr_en && wr_ready;
    assign waddr = MEM_W'(wr_slot) * MEM_W'(CELL_BYTES) + MEM_W'(wr_idx);
    assign raddr = MEM_W'(s_q.rd_slot) * MEM_W'(CELL_BYTES) + MEM_W'(s_q.rd_idx);

    rxp_fill #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS)) i_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (wr_accept),
        .wr_slot (wr_slot),
        .wr_idx  (wr_idx),
        .commit  (commit)
    );

    rxp_cell_store #(.DEPTH(MEM_DEPTH), .DATA_W(DATA_W)) i_store (
        .clk   (clk),
        .we    (wr_accept),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_comb begin
        s_d   = s_q;
        avail = (s_q.rd_idx == '0) ? (s_q.full_cnt != '0) : (s_q.full_cnt > CNT_W'(1));
        take  = s_q.sel && !rx_en_n && (s_q.full_cnt != '0);
        last  = take && (s_q.rd_idx == IDX_W'(CELL_BYTES - 1));

        s_d.clav_oe = (rx_addr == port_addr);
        s_d.clav    = avail;
        if (rx_en_n) s_d.sel = (rx_addr == port_addr);

        s_d.dat_oe = take;
        s_d.soc    = take && (s_q.rd_idx == '0);
        if (take) begin
            s_d.data = rdata;
            s_d.par  = ~^rdata;
            if (last) begin
                s_d.rd_idx  = '0;
                s_d.rd_slot = (s_q.rd_slot == SLOT_W'(SLOTS - 1)) ? '0 : s_q.rd_slot + 1'b1;
            end else begin
                s_d.rd_idx = s_q.rd_idx + 1'b1;
            end
        end

        unique case ({commit, last})
            2'b10:   s_d.full_cnt = s_q.full_cnt + 1'b1;
            2'b01:   s_d.full_cnt = s_q.full_cnt - 1'b1;
            default: s_d.full_cnt = s_q.full_cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_data    = s_q.data;
    assign rx_parity  = s_q.par;
    assign rx_soc     = s_q.soc;
    assign rx_dat_oe  = s_q.dat_oe;
    assign rx_clav    = s_q.clav;
    assign rx_clav_oe = s_q.clav_oe;

    // R2
    clav_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_addr == port_addr) |=> rx_clav_oe);

    // R2
    clav_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_addr != port_addr) |=> !rx_clav_oe);

    // R5
    pause_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_n |=> !rx_dat_oe);

    // R6
    soc_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soc |-> rx_dat_oe);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full_cnt <= CNT_W'(SLOTS));

    // R10
    commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && last) |=> $stable(s_q.full_cnt));
endmodule

// File: tb/test_utopia_rx_port.sv
module test_utopia_rx_port;
    localparam int CELL  = 53;
    localparam int SLOTS = 2;
    localparam logic [4:0] PORT = 5'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] port_addr = PORT;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic [4:0] rx_addr = 5'h00;
    logic       rx_en_n = 1'b1;
    logic [7:0] rx_data;
    logic       rx_parity, rx_soc, rx_dat_oe, rx_clav, rx_clav_oe;

    always #5 clk = ~clk;

    utopia_rx_port i_utopia_rx_port (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rx_addr(rx_addr), .rx_en_n(rx_en_n),
        .rx_data(rx_data), .rx_parity(rx_parity), .rx_soc(rx_soc),
        .rx_dat_oe(rx_dat_oe), .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
    );

    int n_chk = 0, n_bad = 0, n_coin = 0;
    bit done = 0;

    // reference model state
    int m_full = 0, m_widx = 0, m_ridx = 0;
    bit m_sel = 0, have_exp = 0;
    logic [7:0] cq[$], pq[$];
    bit e_coe, e_clav, e_doe, e_soc, e_par;
    logic [7:0] e_data;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit odd_par(logic [7:0] b);
        return ($countones(b) % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic [4:0] other_addr();
        logic [4:0] a = 5'($urandom % 32);
        if (a == PORT) a = a ^ 5'h01;
        return a;
    endfunction

    // one clock: check previous expectations, drive, predict, advance
    task automatic step(input bit wen, input logic [7:0] wd, input logic [4:0] ad, input bit en_n);
        bit ready, avail, take, rel, com;
        if (have_exp) begin
            chk("R2 clav_oe", rx_clav_oe, e_coe);
            if (e_coe) chk("R3 clav", rx_clav, e_clav);
            chk("R4 R5 dat_oe", rx_dat_oe, e_doe);
            if (e_doe) begin
                chk("R5 data", rx_data, e_data);
                chk("R6 soc", rx_soc, e_soc);
                chk("R7 parity", rx_parity, e_par);
            end
        end
        chk("R9 wr_ready", wr_ready, (m_full < SLOTS));
        wr_en = wen; wr_data = wd; rx_addr = ad; rx_en_n = en_n;
        ready = (m_full < SLOTS);
        avail = (m_ridx == 0) ? (m_full > 0) : (m_full > 1);
        e_coe = (ad == PORT);
        e_clav = avail;
        take = m_sel && !en_n && (m_full > 0);
        e_doe = take;
        rel = 0;
        if (take) begin
            e_data = cq.pop_front();
            e_soc = (m_ridx == 0);   // R8: byte 0 of each 53-byte cell
            e_par = odd_par(e_data);
            m_ridx++;
            if (m_ridx == CELL) begin rel = 1; m_ridx = 0; end
        end
        if (en_n) m_sel = (ad == PORT);
        com = 0;
        if (wen && ready) begin
            pq.push_back(wd);
            m_widx++;
            if (m_widx == CELL) begin
                com = 1; m_widx = 0;
                foreach (pq[i]) cq.push_back(pq[i]);
                pq.delete();
            end
        end
        m_full = m_full + int'(com) - int'(rel);
        if (com && rel) n_coin++;
        have_exp = 1;
        @(negedge clk);
    endtask

    task automatic rand_phase(input int cycles, input int wr_pct, input int low_pct);
        for (int i = 0; i < cycles; i++) begin
            bit en_n = ($urandom % 100) >= low_pct;
            logic [4:0] ad;
            if (en_n) ad = (($urandom % 100) < 80) ? PORT : other_addr();
            else      ad = ($urandom % 2) ? PORT : other_addr();
            step((($urandom % 100) < wr_pct), 8'($urandom), ad, en_n);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 clav_oe", rx_clav_oe, 0);
        chk("R1 dat_oe", rx_dat_oe, 0);
        chk("R1 wr_ready", wr_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clav_oe idle", rx_clav_oe, 0);
        chk("R1 dat_oe idle", rx_dat_oe, 0);

        // directed: poll an empty port, then a foreign address
        step(0, 8'h00, PORT, 1);
        step(0, 8'h00, other_addr(), 1);
        step(0, 8'h00, PORT, 0);

        rand_phase(2000, 60, 60);
        rand_phase(600, 95, 10);   // buffer full, writes discarded (R9)
        rand_phase(1500, 5, 85);   // drain, reads with nothing held

        // R10: last write and last read at the same edge
        step(0, 8'h00, PORT, 1);
        while (m_full > 0) step(0, 8'h00, PORT, 0);
        while (!(m_full == 1 && m_widx == CELL - 1)) step(1, 8'($urandom), PORT, 1);
        while (m_ridx != CELL - 1) step(0, 8'h00, PORT, 0);
        step(1, 8'h00, PORT, 0);
        chk("R10 coincidence reached", (n_coin > 0), 1);
        step(0, 8'h00, PORT, 1);
        for (int i = 0; i < CELL + 2; i++) step(0, 8'h00, PORT, 0);

        rand_phase(1000, 50, 50);
        step(0, 8'h00, other_addr(), 1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule